// File: doc/BRIEF.md
# Parallel Flash Command and Word-Program Sequencer

This block is the control front end of a word-wide parallel flash device. It brings the asynchronous chip-select, write-strobe and output-enable inputs (all active low) into the internal clock domain. From the combined write-enable it forms write cycles, which carry an address and a data word. A write is treated as a command. A three-write unlock pattern arms the sequencer, and a fourth write then programs one word of a small on-chip array.

Programming can only clear bits, so the stored word becomes the old value ANDed with the new data. After a program starts, the device stays busy for a parameterized number of clock cycles. While it is busy, reads return a status word instead of array data, and every write is discarded. A host polls the status word until the busy period ends, then reads the array as normal.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `dq_oe` is 0, and every array word reads 16'hFFFF.
- R2: `dq_oe` is 1 exactly when `ce_n` and `oe_n`, each delayed through two clock flops, are both 0. While `dq_oe` is 1 and `busy` is 0, `dout` holds the array word selected by the low `WORD_AW` bits of `addr`.
- R3: While `ce_n` is high, toggling `we_n` or `oe_n` has no effect: there is no output enable, no command step and no array change.
- R4: The write address is captured in the cycle the synchronized combined write-enable (`ce_n` and `we_n` both low) becomes active. The write data is captured in the cycle it becomes inactive. Either strobe may be the one that starts or ends the cycle.
- R5: A program needs these writes in order, with the command byte taken from `din[7:0]`: 8'hAA to address 15'h5555, then 8'h55 to 15'h2AAA, then 8'hA0 to 15'h5555. The next write then programs its address and data.
- R6: A write that breaks the unlock pattern returns the sequencer to its idle step. A following write then programs nothing.
- R7: A program stores the old word ANDed with the new data.
- R8: `busy` rises in the cycle after the end of the programming write is detected. It stays high for exactly `BUSY_CYCLES` cycles.
- R9: While `busy` is high, a read returns a status word. Bit 7 is the complement of bit 7 of the data being programmed. Bit 6 flips at the start of each read. All other bits are 0.
- R10: Any write whose end is detected while `busy` is high is ignored, including one that ends in the last busy cycle.
- R11: After `busy` falls, reads return array contents again, including the newly programmed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data or status word |
| dq_oe | output | 1 | Drive enable for the data bus; 0 means high-impedance |
| busy | output | 1 | Internal program operation in progress |

## Verification
Two functions can fall in the same cycle: the busy timer's final cycle, and the detected end of a new write. The bench provokes this by holding a write open during a program. It releases the strobes at a point chosen so that the write's end is detected exactly on the last busy cycle. The write is judged correct if it is discarded. A reference model, stepped on every clock, must agree that the unlock step does not advance. A later full sequence aimed at the same word must also leave that word unchanged.

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl #(
  parameter int AW          = 15,
  parameter int DW          = 16,
  parameter int WORD_AW     = 4,
  parameter int BUSY_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dq_oe,
  output logic          busy
);
  localparam int WORDS = 1 << WORD_AW;
  localparam int CW    = $clog2(BUSY_CYCLES + 1);
  localparam logic [AW-1:0] KEY_A = AW'(15'h5555);
  localparam logic [AW-1:0] KEY_B = AW'(15'h2AAA);

  typedef enum logic [1:0] {IDLE, GOT_AA, GOT_55, ARMED} step_t;

  logic [2:0]    sy1, sy2;
  logic          wr, rd, wr_q, rd_q, wr_start, wr_end;
  logic [AW-1:0] addr_l;
  step_t         st;
  logic          busy_r, tog, tgt7;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] status;

  assign wr       = ~sy2[2] & ~sy2[1];
  assign rd       = ~sy2[2] & ~sy2[0];
  assign wr_start = wr & ~wr_q;
  assign wr_end   = ~wr & wr_q;
  assign status   = DW'({~tgt7, tog, 6'b0});
  assign busy     = busy_r;
  assign dq_oe    = rd;
  assign dout     = busy_r ? status : mem[addr[WORD_AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1    <= '1;
      sy2    <= '1;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      addr_l <= '0;
      st     <= IDLE;
      busy_r <= 1'b0;
      cnt    <= '0;
      tog    <= 1'b0;
      tgt7   <= 1'b0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else begin
      sy1  <= {ce_n, we_n, oe_n};
      sy2  <= sy1;
      wr_q <= wr;
      rd_q <= rd;
      if (wr_start) addr_l <= addr;
      if (rd && !rd_q && busy_r) tog <= ~tog;
      if (busy_r) begin
        if (cnt == '0) busy_r <= 1'b0;
        else           cnt    <= cnt - 1'b1;
      end
      if (wr_end && !busy_r) begin
        case (st)
          IDLE:    st <= (addr_l == KEY_A && din[7:0] == 8'hAA) ? GOT_AA : IDLE;
          GOT_AA:  st <= (addr_l == KEY_B && din[7:0] == 8'h55) ? GOT_55 : IDLE;
          GOT_55:  st <= (addr_l == KEY_A && din[7:0] == 8'hA0) ? ARMED  : IDLE;
          default: begin
            mem[addr_l[WORD_AW-1:0]] <= mem[addr_l[WORD_AW-1:0]] & din;
            tgt7   <= din[7];
            busy_r <= 1'b1;
            cnt    <= CW'(BUSY_CYCLES - 1);
            st     <= IDLE;
          end
        endcase
      end
    end
  end
endmodule

module flash_prog_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          busy,
  input logic [DW-1:0] dout,
  input logic [1:0]    st
);
  // R2
  oe_follows_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!$past(ce_n, 2) && !$past(oe_n, 2)));
  // R9
  status_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> (dout[5:0] == '0 && (dout >> 8) == '0));
  // R10
  no_step_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(st));
  // R5
  armed_before_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(st) == 2'd3);
  // R8
  busy_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
  .dq_oe(dq_oe), .busy(busy_r), .dout(dout), .st(st)
);

// File: tb/test_flash_prog_ctrl.sv
`timescale 1ns/1ps
module test_flash_prog_ctrl;
  localparam int BUSY = 40;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic [14:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic dq_oe, busy;
  int checks = 0, failures = 0, busy_seen = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  flash_prog_ctrl #(.BUSY_CYCLES(BUSY)) i_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe), .busy(busy));

  // behavioural reference model
  logic [2:0]  syncq[$] = '{3'b111, 3'b111};
  logic [15:0] m_mem [16];
  logic [14:0] m_addr;
  bit m_wrq, m_rdq, m_busy, m_tog, m_t7;
  int m_cnt, m_step;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncq = '{3'b111, 3'b111};
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
      m_addr = 0; m_wrq = 0; m_rdq = 0; m_busy = 0; m_tog = 0; m_t7 = 0;
      m_cnt = 0; m_step = 0;
    end else begin
      automatic logic [2:0] s = syncq[0];
      automatic bit w = !s[2] && !s[1];
      automatic bit r = !s[2] && !s[0];
      automatic bit ob = m_busy;
      automatic bit start = 0;
      if (w && !m_wrq) m_addr = addr;
      if (!w && m_wrq && !ob) begin
        if (m_step == 3) begin
          m_mem[m_addr[3:0]] = m_mem[m_addr[3:0]] & din;
          m_t7 = din[7]; start = 1; m_step = 0;
        end else if (m_step == 0 && m_addr == 15'h5555 && din[7:0] == 8'hAA) m_step = 1;
        else if (m_step == 1 && m_addr == 15'h2AAA && din[7:0] == 8'h55) m_step = 2;
        else if (m_step == 2 && m_addr == 15'h5555 && din[7:0] == 8'hA0) m_step = 3;
        else m_step = 0;
      end
      if (r && !m_rdq && ob) m_tog = !m_tog;
      if (ob) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt--;
      end
      if (start) begin m_busy = 1; m_cnt = BUSY - 1; end
      m_wrq = w; m_rdq = r;
      void'(syncq.pop_front());
      syncq.push_back({ce_n, we_n, oe_n});
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    automatic bit eo = !syncq[0][2] && !syncq[0][0];
    automatic logic [15:0] ed = m_busy ? {8'h00, !m_t7, m_tog, 6'b0} : m_mem[addr[3:0]];
    if (busy) busy_seen++;
    chk(busy == m_busy, {cur_req, " busy"}, 16'(busy), 16'(m_busy));
    chk(dq_oe == eo, {cur_req, " dq_oe"}, 16'(dq_oe), 16'(eo));
    if (eo) chk(dout == ed, {cur_req, " dout"}, dout, ed);
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [14:0] a, input logic [15:0] d);
    addr = a; din = d; ce_n = 0; we_n = 0;
    repeat (4) tick();
    ce_n = 1; we_n = 1;
    repeat (4) tick();
  endtask

  task automatic prog(input logic [14:0] a, input logic [15:0] d);
    wr(15'h5555, 16'h00AA); wr(15'h2AAA, 16'h0055); wr(15'h5555, 16'h00A0); wr(a, d);
  endtask

  task automatic rd(input logic [14:0] a, output logic [15:0] q);
    addr = a; ce_n = 0; oe_n = 0;
    repeat (3) tick();
    @(negedge clk); q = dout;
    tick(); ce_n = 1; oe_n = 1;
    repeat (2) tick();
  endtask

  task automatic wait_idle(); while (busy) tick(); tick(); endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; failures++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] q, q2;
    repeat (3) tick(); rst_n = 1; tick();
    @(negedge clk);
    chk(!busy && !dq_oe, "R1 reset outputs", {14'b0, busy, dq_oe}, 16'h0);
    rd(15'h0003, q); chk(q == 16'hFFFF, "R1 erased word", q, 16'hFFFF);
    rd(15'h000C, q); chk(q == 16'hFFFF, "R2 read path", q, 16'hFFFF);

    cur_req = "R3";
    addr = 15'h5555; din = 16'h00AA; oe_n = 0;
    repeat (3) begin we_n = 0; repeat (4) tick(); we_n = 1; repeat (4) tick(); end
    @(negedge clk); chk(!dq_oe, "R3 deselected no drive", 16'(dq_oe), 16'h0);
    oe_n = 1; tick();
    wr(15'h2AAA, 16'h0055); wr(15'h5555, 16'h00A0); wr(15'h0003, 16'h0000);
    @(negedge clk); chk(!busy, "R3 strobes with ce high ignored", 16'(busy), 16'h0);

    cur_req = "R5"; busy_seen = 0;
    prog(15'h0003, 16'h1234);
    @(negedge clk); chk(busy, "R5 program after unlock", 16'(busy), 16'h1);
    cur_req = "R9";
    rd(15'h0003, q); rd(15'h0003, q2);
    chk(q[7] == 1'b1, "R9 status bit7", 16'(q[7]), 16'h1);
    chk(q[6] != q2[6], "R9 toggle bit", 16'(q2[6]), 16'(!q[6]));
    wait_idle();
    chk(busy_seen == BUSY, "R8 busy length", 16'(busy_seen), 16'(BUSY));
    cur_req = "R11";
    rd(15'h0003, q); chk(q == 16'h1234, "R11 data after program", q, 16'h1234);

    cur_req = "R7";
    prog(15'h0003, 16'hFF0F); wait_idle();
    rd(15'h0003, q); chk(q == 16'h1204, "R7 AND of old and new", q, 16'h1204);

    cur_req = "R4";
    wr(15'h5555, 16'h00AA); wr(15'h2AAA, 16'h0055); wr(15'h5555, 16'h00A0);
    addr = 15'h0005; din = 16'hBEEF; ce_n = 0; tick(); tick(); we_n = 0;
    repeat (4) tick();
    addr = 15'h0009; din = 16'h00F0; tick();
    we_n = 1; tick(); tick(); ce_n = 1; repeat (4) tick();
    wait_idle();
    rd(15'h0005, q); chk(q == 16'h00F0, "R4 addr at start data at end", q, 16'h00F0);
    rd(15'h0009, q); chk(q == 16'hFFFF, "R4 late addr unused", q, 16'hFFFF);

    cur_req = "R6";
    wr(15'h5555, 16'h00AA); wr(15'h2AAA, 16'h0055); wr(15'h5555, 16'h0090);
    wr(15'h0005, 16'h0000);
    @(negedge clk); chk(!busy, "R6 broken sequence", 16'(busy), 16'h0);
    rd(15'h0005, q); chk(q == 16'h00F0, "R6 word unchanged", q, 16'h00F0);

    cur_req = "R10";
    prog(15'h0007, 16'h0101);
    prog(15'h0009, 16'h0000);
    addr = 15'h5555; din = 16'h00AA; ce_n = 0; we_n = 0;
    while (!(m_busy && m_cnt == 2)) tick();
    ce_n = 1; we_n = 1; repeat (4) tick();
    @(negedge clk); chk(!busy, "R10 collision cycle ended busy", 16'(busy), 16'h0);
    wr(15'h2AAA, 16'h0055); wr(15'h5555, 16'h00A0); wr(15'h0007, 16'h0000);
    @(negedge clk); chk(!busy, "R10 collided write discarded", 16'(busy), 16'h0);
    rd(15'h0007, q); chk(q == 16'h0101, "R10 word kept", q, 16'h0101);
    rd(15'h0009, q); chk(q == 16'hFFFF, "R10 busy-time program ignored", q, 16'hFFFF);

    repeat (4) tick();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule